// File: doc/BRIEF.md
# Dual-Sequence Conversion Scheduler

This block decides which analog channel a shared converter samples next. Two sequences, A (index 0) and B (index 1), each own a channel mask, a choice of hardware trigger inputs with a launch edge, a software start strobe, and mode bits for burst, single-step and flag granularity. When a sequence is launched, the scheduler steps through the selected channels from the lowest number upward. For each channel it sends one start pulse, with a channel number and a sequence tag, to the converter. It then waits for the converter's done strobe before it issues anything more.

Only one conversion is in flight at any time. When both sequences have work, the one marked high priority gets the converter at the next conversion boundary. The other keeps its remaining channels and carries on from where it stopped once the high-priority pass ends. Each hardware trigger path either runs through a two-stage synchronizer and an edge detector, or takes a bypass that saves two cycles of latency. Each sequence raises a one-cycle flag, used as an interrupt or DMA request, either after every conversion or once its whole pass has completed.

Top module: `dual_seq_sched`

## Requirements
- R1: A launched pass converts every channel whose bit is set in that sequence's 12-bit mask, one channel per conversion, in ascending channel order, and none of the others.
- R2: A sequence launches on an edge of the OR of the hardware trigger inputs selected by its 6-bit trigger mask. The polarity bit chooses the edge: 1 selects rising, 0 selects falling. Inputs outside the mask, and edges of the other polarity, launch nothing.
- R3: While a sequence's enable is low, its software start and hardware triggers launch nothing, and any pass it had in progress is abandoned.
- R4: With burst set, an enabled sequence relaunches by itself as soon as its pass ends, and ignores start and trigger events. Clearing burst lets the pass in progress finish, and after that no further conversions are issued.
- R5: With single-step set, each launch converts only the next remaining channel of the pass. After the last channel, the next launch begins again at the lowest selected channel.
- R6: When both sequences want the converter, the high-priority one is issued first (hi_sel_i = 0 makes A high, 1 makes B high). The conversion already in flight is not aborted. A displaced sequence resumes at its first channel not yet converted.
- R7: Flag mode 0 pulses the sequence's flag after every conversion it completes. Mode 1 pulses the flag only after the last channel of a pass. The pulse is high for the one cycle after the clock edge that samples conv_done_i.
- R8: A launch sampled at clock edge k (from a software start, or a bypassed trigger input changing before edge k) produces conv_start_o in the cycle after edge k+1. A synchronized trigger produces it two cycles later.
- R9: conv_start_o is a one-cycle pulse. No new start is issued until conv_done_i has been seen for the conversion in flight.
- R10: After reset no conversion is in flight, no sequence is active, and conv_start_o and both flags are low.
- R11: Launching a sequence whose channel mask is all zeros issues no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_en_i | input | 2 | Per-sequence enable (bit 0 = A, bit 1 = B) |
| burst_i | input | 2 | Per-sequence burst mode |
| step_i | input | 2 | Per-sequence single-step mode |
| irq_mode_i | input | 2 | Per-sequence flag mode: 0 every conversion, 1 end of pass |
| sync_bypass_i | input | 2 | Per-sequence bypass of the trigger synchronizer |
| trig_rise_i | input | 2 | Per-sequence trigger polarity: 1 rising, 0 falling |
| sw_start_i | input | 2 | Per-sequence one-cycle software start strobe |
| chan_mask_i | input | 2x12 | Per-sequence channel selection |
| trig_mask_i | input | 2x6 | Per-sequence hardware trigger selection |
| hi_sel_i | input | 1 | Index of the high-priority sequence |
| hw_trig_i | input | 6 | Hardware trigger inputs |
| conv_done_i | input | 1 | Converter finished the conversion in flight |
| conv_start_o | output | 1 | One-cycle start request to the converter |
| conv_chan_o | output | 4 | Channel for the current request |
| conv_seq_o | output | 1 | Sequence that owns the current request |
| seq_flag_o | output | 2 | Per-sequence interrupt/DMA flag pulse |

## Verification
Every result has a fixed delay. The start pulse appears two edges after a software start or a bypassed trigger is sampled, and four edges after a synchronized trigger. A flag appears one edge after the done strobe, and the next start follows one edge after that. The bench drives all inputs and samples all outputs on the falling clock edge. It counts those edges exactly: it checks that the output is still low one cycle early and high in the cycle it is due. Where an event must have no effect, it watches conv_start_o for a window well beyond the longest latency.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int unsigned NUM_SEQ  = 2;
  localparam int unsigned NUM_CH   = 12;
  localparam int unsigned NUM_TRIG = 6;

  typedef enum logic {
    FLAG_EACH_CONV = 1'b0,
    FLAG_END_PASS  = 1'b1
  } flag_mode_e;
endpackage

// File: rtl/dss_trig_sync.sv
module dss_trig_sync #(
  parameter int unsigned NUM_TRIG = dss_pkg::NUM_TRIG
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [NUM_TRIG-1:0] mask_i,
  input  logic                rise_i,
  input  logic                bypass_i,
  output logic                edge_o
);
  logic raw, raw_q, s1_q, s2_q, s3_q, cur, old;

  assign raw = |(trig_i & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
    end else begin
      raw_q <= raw;
      s1_q  <= raw;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
    end
  end

  // bypass compares live input with last sample; otherwise the two-flop output
  assign cur    = bypass_i ? raw   : s2_q;
  assign old    = bypass_i ? raw_q : s3_q;
  assign edge_o = rise_i ? (cur & ~old) : (~cur & old);
endmodule

// File: rtl/dss_seq_ctrl.sv
module dss_seq_ctrl #(
  parameter int unsigned NUM_CH = dss_pkg::NUM_CH,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              burst_i,
  input  logic              step_i,
  input  logic              mode_i,
  input  logic [NUM_CH-1:0] chan_mask_i,
  input  logic              sw_start_i,
  input  logic              trig_edge_i,
  input  logic              done_i,
  input  logic [CH_W-1:0]   done_chan_i,
  output logic              req_o,
  output logic [CH_W-1:0]   next_chan_o,
  output logic              flag_o
);
  import dss_pkg::*;

  logic [NUM_CH-1:0] rem_q, load_mask, rem_after;
  logic              active_q, flag_q, launch_req, launch;
  flag_mode_e        mode;

  assign mode       = flag_mode_e'(mode_i);
  assign launch_req = burst_i ? 1'b1 : (sw_start_i | trig_edge_i);
  assign launch     = en_i & ~active_q & launch_req;
  assign load_mask  = (rem_q == '0) ? chan_mask_i : rem_q;
  assign rem_after  = rem_q & ~(NUM_CH'(1) << done_chan_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      flag_q   <= 1'b0;
    end else if (!en_i) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      flag_q <= 1'b0;
      if (done_i) begin
        rem_q  <= rem_after;
        flag_q <= (mode == FLAG_EACH_CONV) || (rem_after == '0);
        if (step_i || rem_after == '0) active_q <= 1'b0;
      end else if (launch) begin
        rem_q    <= load_mask;
        active_q <= (load_mask != '0);
      end
    end
  end

  always_comb begin
    next_chan_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (rem_q[i]) next_chan_o = CH_W'(i);
    end
  end

  assign req_o  = active_q;
  assign flag_o = flag_q;

  p_active_has_work_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (rem_q != '0));
  p_disabled_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_q);
  p_step_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && done_i) |=> !active_q);
  p_flag_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> $past(done_i));
endmodule

// File: rtl/dss_conv_if.sv
module dss_conv_if #(
  parameter int unsigned NUM_CH = dss_pkg::NUM_CH,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned NS    = dss_pkg::NUM_SEQ
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NS-1:0]            req_i,
  input  logic [NS-1:0][CH_W-1:0]  chan_i,
  input  logic                     hi_sel_i,
  input  logic                     conv_done_i,
  output logic                     conv_start_o,
  output logic [CH_W-1:0]          conv_chan_o,
  output logic                     conv_seq_o,
  output logic [NS-1:0]            done_o,
  output logic [CH_W-1:0]          done_chan_o
);
  logic            busy_q, start_q, seq_q, sel, issue;
  logic [CH_W-1:0] chan_q;

  // fixed priority at each conversion boundary
  assign sel   = (req_i == 2'b11) ? hi_sel_i : req_i[1];
  assign issue = ~busy_q & (|req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      seq_q   <= 1'b0;
      chan_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (issue) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        seq_q   <= sel;
        chan_q  <= chan_i[sel];
      end else if (busy_q && conv_done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign conv_start_o = start_q;
  assign conv_chan_o  = chan_q;
  assign conv_seq_o   = seq_q;
  assign done_chan_o  = chan_q;
  assign done_o       = (busy_q && conv_done_i) ? (NS'(1) << seq_q) : '0;

  p_start_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  p_one_in_flight_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !conv_done_i) |=> !conv_start_o);
  p_high_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && req_i == 2'b11) |=> (conv_seq_o == $past(hi_sel_i)));
  p_done_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
endmodule

// File: rtl/dual_seq_sched.sv
module dual_seq_sched #(
  parameter int unsigned NUM_CH   = dss_pkg::NUM_CH,
  parameter int unsigned NUM_TRIG = dss_pkg::NUM_TRIG,
  localparam int unsigned CH_W    = $clog2(NUM_CH),
  localparam int unsigned NS      = dss_pkg::NUM_SEQ
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NS-1:0]               seq_en_i,
  input  logic [NS-1:0]               burst_i,
  input  logic [NS-1:0]               step_i,
  input  logic [NS-1:0]               irq_mode_i,
  input  logic [NS-1:0]               sync_bypass_i,
  input  logic [NS-1:0]               trig_rise_i,
  input  logic [NS-1:0]               sw_start_i,
  input  logic [NS-1:0][NUM_CH-1:0]   chan_mask_i,
  input  logic [NS-1:0][NUM_TRIG-1:0] trig_mask_i,
  input  logic                        hi_sel_i,
  input  logic [NUM_TRIG-1:0]         hw_trig_i,
  input  logic                        conv_done_i,
  output logic                        conv_start_o,
  output logic [CH_W-1:0]             conv_chan_o,
  output logic                        conv_seq_o,
  output logic [NS-1:0]               seq_flag_o
);
  logic [NS-1:0]           trig_edge, req, done;
  logic [NS-1:0][CH_W-1:0] next_chan;
  logic [CH_W-1:0]         done_chan;

  for (genvar s = 0; s < NS; s++) begin : g_seq
    dss_trig_sync #(.NUM_TRIG(NUM_TRIG)) u_trig (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .trig_i   (hw_trig_i),
      .mask_i   (trig_mask_i[s]),
      .rise_i   (trig_rise_i[s]),
      .bypass_i (sync_bypass_i[s]),
      .edge_o   (trig_edge[s])
    );

    dss_seq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (seq_en_i[s]),
      .burst_i     (burst_i[s]),
      .step_i      (step_i[s]),
      .mode_i      (irq_mode_i[s]),
      .chan_mask_i (chan_mask_i[s]),
      .sw_start_i  (sw_start_i[s]),
      .trig_edge_i (trig_edge[s]),
      .done_i      (done[s]),
      .done_chan_i (done_chan),
      .req_o       (req[s]),
      .next_chan_o (next_chan[s]),
      .flag_o      (seq_flag_o[s])
    );
  end

  dss_conv_if #(.NUM_CH(NUM_CH)) u_conv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req),
    .chan_i       (next_chan),
    .hi_sel_i     (hi_sel_i),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .conv_chan_o  (conv_chan_o),
    .conv_seq_o   (conv_seq_o),
    .done_o       (done),
    .done_chan_o  (done_chan)
  );
endmodule

// File: tb/dual_seq_sched_tb.sv
`timescale 1ns/1ps
module dual_seq_sched_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] seq_en, burst, step, irq_mode, bypass, rise, sw_start, seq_flag;
  logic [1:0][11:0] chan_mask;
  logic [1:0][5:0]  trig_mask;
  logic hi_sel, conv_done, conv_start, conv_seq;
  logic [5:0] hw_trig;
  logic [3:0] conv_chan;
  int nvec = 0, nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_seq_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n), .seq_en_i(seq_en), .burst_i(burst), .step_i(step),
    .irq_mode_i(irq_mode), .sync_bypass_i(bypass), .trig_rise_i(rise), .sw_start_i(sw_start),
    .chan_mask_i(chan_mask), .trig_mask_i(trig_mask), .hi_sel_i(hi_sel), .hw_trig_i(hw_trig),
    .conv_done_i(conv_done), .conv_start_o(conv_start), .conv_chan_o(conv_chan),
    .conv_seq_o(conv_seq), .seq_flag_o(seq_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sw_pulse(input int s);
    sw_start[s] = 1'b1;
    @(negedge clk);
    sw_start[s] = 1'b0;
  endtask

  task automatic wait_start(input int s, input int ch, input string req);
    int t = 0;
    while (!conv_start && t < 60) begin
      @(negedge clk);
      t++;
    end
    chk(conv_start == 1'b1, {req, " start"}, int'(conv_start), 1);
    chk(conv_seq == s[0] && conv_chan == ch[3:0], {req, " seq*16+chan"},
        int'(conv_seq) * 16 + int'(conv_chan), s * 16 + ch);
  endtask

  task automatic finish_conv(input int s, input bit flag, input string req);
    @(negedge clk);
    chk(conv_start == 1'b0, "R9 start pulse width", int'(conv_start), 0);
    @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    chk(seq_flag[s] == flag, {req, " flag"}, int'(seq_flag[s]), int'(flag));
  endtask

  task automatic serve(input int s, input int ch, input bit flag, input string req);
    wait_start(s, ch, req);
    finish_conv(s, flag, req);
  endtask

  task automatic no_start(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (conv_start) seen = 1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  function automatic int last_bit(input logic [11:0] m);
    int r = -1;
    for (int i = 0; i < 12; i++) if (m[i]) r = i;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    seq_en = 2'b11; burst = 0; step = 0; irq_mode = 0; bypass = 2'b11; rise = 2'b11;
    sw_start = 0; chan_mask = '0; trig_mask = '0; hi_sel = 0; hw_trig = 0; conv_done = 0;
    repeat (3) @(negedge clk);
    chk(conv_start == 0 && seq_flag == 0, "R10 reset outputs", int'({conv_start, seq_flag}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(conv_start == 0 && seq_flag == 0, "R10 after reset", int'({conv_start, seq_flag}), 0);
    no_start(5, "R10 idle after reset");

    // R1 / R7 random masks and flag modes
    for (int it = 0; it < 10; it++) begin
      int s = int'($urandom % 2);
      logic [11:0] m = 12'($urandom) | (12'd1 << ($urandom % 12));
      int lb = last_bit(m);
      irq_mode[s] = 1'($urandom);
      chan_mask[s] = m;
      @(negedge clk);
      sw_pulse(s);
      chk(conv_start == 0, "R8 start not before edge k+1", int'(conv_start), 0);
      @(negedge clk);
      chk(conv_start == 1, "R8 start after sw launch", int'(conv_start), 1);
      for (int c = 0; c < 12; c++) begin
        if (m[c]) serve(s, c, (irq_mode[s] == 1'b0) || (c == lb), "R1 R7 random pass");
      end
      no_start(8, "R1 no extra conversion");
    end
    irq_mode = 2'b11;

    // R11 empty mask
    chan_mask[0] = '0;
    @(negedge clk);
    sw_pulse(0);
    no_start(8, "R11 empty mask");

    // R8 / R2 bypassed rising trigger
    chan_mask[0] = 12'h008;
    trig_mask[0] = 6'b000100;
    @(negedge clk);
    hw_trig[2] = 1'b1;
    @(negedge clk);
    chk(conv_start == 0, "R8 bypass early", int'(conv_start), 0);
    @(negedge clk);
    chk(conv_start == 1, "R8 bypass due", int'(conv_start), 1);
    serve(0, 3, 1, "R2 rising trigger");
    hw_trig[2] = 1'b0;
    no_start(8, "R2 falling edge ignored when rising selected");

    // R8 synchronized trigger
    bypass[0] = 1'b0;
    @(negedge clk);
    hw_trig[2] = 1'b1;
    repeat (3) @(negedge clk);
    chk(conv_start == 0, "R8 sync early", int'(conv_start), 0);
    @(negedge clk);
    chk(conv_start == 1, "R8 sync due", int'(conv_start), 1);
    serve(0, 3, 1, "R8 sync pass");
    hw_trig[2] = 1'b0;
    no_start(8, "R2 sync release ignored");

    // R2 falling polarity
    bypass[0] = 1'b1;
    rise[0] = 1'b0;
    @(negedge clk);
    hw_trig[2] = 1'b1;
    no_start(8, "R2 rising edge ignored when falling selected");
    hw_trig[2] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(conv_start == 1, "R2 falling launch", int'(conv_start), 1);
    serve(0, 3, 1, "R2 falling pass");
    rise[0] = 1'b1;

    // R2 unmasked input
    hw_trig[0] = 1'b1;
    no_start(6, "R2 unmasked rise");
    hw_trig[0] = 1'b0;
    no_start(6, "R2 unmasked fall");

    // R3 disabled
    seq_en[0] = 1'b0;
    @(negedge clk);
    sw_pulse(0);
    hw_trig[2] = 1'b1;
    no_start(10, "R3 disabled ignores launches");
    hw_trig[2] = 1'b0;
    seq_en[0] = 1'b1;
    no_start(4, "R3 re-enable alone");

    // R5 single step
    step[0] = 1'b1;
    chan_mask[0] = 12'h205;
    @(negedge clk);
    sw_pulse(0);
    serve(0, 0, 0, "R5 step 1");
    no_start(8, "R5 one channel per launch");
    sw_pulse(0);
    serve(0, 2, 0, "R5 step 2");
    sw_pulse(0);
    serve(0, 9, 1, "R5 step last");
    sw_pulse(0);
    serve(0, 0, 0, "R5 wrap to lowest");
    step[0] = 1'b0;
    seq_en[0] = 1'b0;
    @(negedge clk);
    seq_en[0] = 1'b1;

    // R4 burst
    irq_mode[1] = 1'b0;
    chan_mask[1] = 12'h030;
    burst[1] = 1'b1;
    serve(1, 4, 1, "R4 burst pass1");
    serve(1, 5, 1, "R4 burst pass1");
    serve(1, 4, 1, "R4 burst relaunch");
    burst[1] = 1'b0;
    serve(1, 5, 1, "R4 pass completes after clear");
    no_start(10, "R4 stops after clear");
    irq_mode[1] = 1'b1;

    // R6 B high preempts A
    hi_sel = 1'b1;
    chan_mask[0] = 12'h00E;
    chan_mask[1] = 12'h300;
    @(negedge clk);
    sw_pulse(0);
    wait_start(0, 1, "R6 A first");
    sw_pulse(1);
    finish_conv(0, 0, "R6 A first");
    serve(1, 8, 0, "R6 B preempts");
    serve(1, 9, 1, "R6 B ends");
    serve(0, 2, 0, "R6 A resumes");
    serve(0, 3, 1, "R6 A ends");

    // R6 A high preempts B
    hi_sel = 1'b0;
    @(negedge clk);
    sw_pulse(1);
    wait_start(1, 8, "R6 B first");
    sw_pulse(0);
    finish_conv(1, 0, "R6 B first");
    serve(0, 1, 0, "R6 A preempts");
    serve(0, 2, 0, "R6 A preempts");
    serve(0, 3, 1, "R6 A ends");
    serve(1, 9, 1, "R6 B resumes");
    no_start(8, "R6 all done");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule